// File: doc/BRIEF.md
# Standby Entry and Key-Change Wakeup Controller

This block decides when the CPU clock of a small microcontroller runs. Software stops the clock by writing a reserved stop code into the clock-control register. While the clock is stopped the block watches two kinds of wakeup source. The first is an 8-bit key port, compared against a snapshot of that port. The second is a set of six interrupt request lines. When an enabled source qualifies, the block turns the CPU clock back on. It also resets the clock divider to divide-by-8, so the CPU restarts at a safe speed.

Reading the key-latch register has a side effect: it copies the live key port into the snapshot. After that, any difference between the port and the snapshot is a key wakeup condition. This holds even if the difference appeared before standby was entered. The block runs on an always-on reference clock. It is organised around a two-state machine. State `ST_RUN` moves to `ST_STANDBY` on transition `T_STOP`, which is a write of the stop code. State `ST_STANDBY` moves back to `ST_RUN` on transition `T_WAKE`, which happens when the registered wakeup request is seen. No register is cleared on either transition.

Top module: `stby_wake_ctrl`

## Requirements
- R1: After reset, `cpu_clk_en` is 1, `div_sel` is 3 (divide-by-8), the wake-enable register (address 2) reads 0 and the snapshot (address 3) reads 0.
- R2: A read at address 1 returns the live key port in bits 7:0 and copies it into the snapshot, which is then readable at address 3 without side effect.
- R3: A write at address 0 with bits 2:0 equal to 7 (stop code) takes transition T_STOP: `cpu_clk_en` is 0 after that clock edge, and `div_sel` is unchanged.
- R4: A write at address 0 with bits 2:0 in 0..6 sets `div_sel` to that value, readable at address 0 bits 2:0.
- R5: In ST_STANDBY, with wake-enable bit 0 set and the key port different from the snapshot at a clock edge, `cpu_clk_en` is still 0 after that edge and 1 after the next edge (T_WAKE).
- R6: With wake-enable bit 0 clear, or with the key port equal to the snapshot, the key port causes no wakeup.
- R7: Wake-enable bit n (n = 1..6) lets IRQ line n (`irq_in[n-1]`) wake with the R5 timing; an IRQ line whose enable bit is clear causes no wakeup.
- R8: Every T_WAKE sets `div_sel` to 3, whatever value it held before.
- R9: In ST_RUN, wakeup conditions have no effect: `cpu_clk_en` stays 1 and `div_sel` keeps its written value.
- R10: A key difference that arises after the latch read but before T_STOP wakes at once: `cpu_clk_en` is low for exactly two edges.
- R11: The wake-enable register and the snapshot keep their values across T_STOP and T_WAKE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data (combinational on addr) |
| key_in | input | 8 | Live key port |
| irq_in | input | 6 | IRQ lines 1..6 |
| cpu_clk_en | output | 1 | CPU clock enable |
| div_sel | output | 3 | CPU clock divider code |

## Verification
On every cycle, the assertions check four things. A stop write always drops the clock enable. Every rise of the clock enable comes with the divide-by-8 code. The registered wakeup request stays low outside standby. With no request pending, standby is held. The bench scenarios cover the rest. These are the exact two-edge wakeup latency, the sweep over all eight key bits and all six IRQ lines with their enable masks, and the case of a key change made before entry. They also show that the enable and snapshot registers survive a full standby round trip.

// File: rtl/stby_pkg.sv
package stby_pkg;
    typedef enum logic {ST_RUN = 1'b0, ST_STANDBY = 1'b1} stby_state_t;
    localparam int KEY_W   = 8;
    localparam int IRQ_N   = 6;
    localparam int DIV_W   = 3;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 2;
    localparam logic [ADDR_W-1:0] A_CLKCTL = 2'd0;
    localparam logic [ADDR_W-1:0] A_LATCH  = 2'd1;
    localparam logic [ADDR_W-1:0] A_WEN    = 2'd2;
    localparam logic [ADDR_W-1:0] A_SNAP   = 2'd3;
    localparam logic [DIV_W-1:0]  STOP_CODE = 3'd7;
    localparam logic [DIV_W-1:0]  SAFE_DIV  = 3'd3;
endpackage

// File: rtl/stby_key_snap.sv
module stby_key_snap
    import stby_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [KEY_W-1:0] key_in,
    output logic [KEY_W-1:0] snap,
    output logic             differs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap <= '0;
        else if (capture) snap <= key_in;
    end

    assign differs = (key_in != snap);

    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (snap == $past(key_in))); // R2
endmodule

// File: rtl/stby_wake_src.sv
module stby_wake_src
    import stby_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic [IRQ_N:0]   en_wdata,
    input  logic             in_standby,
    input  logic             key_differs,
    input  logic [IRQ_N-1:0] irq_in,
    output logic [IRQ_N:0]   wake_en,
    output logic             wake_q
);
    logic [IRQ_N-1:0] irq_hit;
    logic             cond;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wake_en <= '0;
        else if (en_wr) wake_en <= en_wdata;
    end

    genvar g;
    generate
        for (g = 0; g < IRQ_N; g++) begin : g_irq
            assign irq_hit[g] = irq_in[g] & wake_en[g+1];
        end
    endgenerate

    assign cond = (wake_en[0] & key_differs) | (|irq_hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= cond & in_standby;
    end

    AST_NO_WAKE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_standby |=> !wake_q); // R9
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_wr,
    input  logic [DIV_W-1:0] clk_wdata,
    input  logic             wake_q,
    output logic             in_standby,
    output logic             cpu_clk_en,
    output logic [DIV_W-1:0] div_sel
);
    stby_state_t state, state_nx;
    logic        stop_wr;

    assign stop_wr = clk_wr && (clk_wdata == STOP_CODE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:     if (stop_wr) state_nx = ST_STANDBY;
            ST_STANDBY: if (wake_q)  state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_sel <= SAFE_DIV;
        else if (state == ST_STANDBY && wake_q)
            div_sel <= SAFE_DIV;
        else if (clk_wr && !stop_wr)
            div_sel <= clk_wdata;
    end

    assign in_standby = (state == ST_STANDBY);
    assign cpu_clk_en = (state == ST_RUN);

    AST_STOP_DROPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && stop_wr) |=> !cpu_clk_en); // R3
    AST_WAKE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && wake_q) |=> cpu_clk_en); // R5
    AST_WAKE_SAFE_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && wake_q) |=> (div_sel == SAFE_DIV)); // R8
    AST_HOLD_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && !wake_q) |=> !cpu_clk_en); // R6
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
    import stby_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    input  logic [7:0]        key_in,
    input  logic [5:0]        irq_in,
    output logic              cpu_clk_en,
    output logic [2:0]        div_sel
);
    logic [KEY_W-1:0] snap;
    logic             key_differs;
    logic [IRQ_N:0]   wake_en;
    logic             wake_q;
    logic             in_standby;

    stby_key_snap u_snap (
        .clk(clk), .rst_n(rst_n),
        .capture(rd_en && addr == A_LATCH),
        .key_in(key_in), .snap(snap), .differs(key_differs)
    );

    stby_wake_src u_src (
        .clk(clk), .rst_n(rst_n),
        .en_wr(wr_en && addr == A_WEN),
        .en_wdata(wr_data[IRQ_N:0]),
        .in_standby(in_standby), .key_differs(key_differs),
        .irq_in(irq_in), .wake_en(wake_en), .wake_q(wake_q)
    );

    stby_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .clk_wr(wr_en && addr == A_CLKCTL),
        .clk_wdata(wr_data[DIV_W-1:0]),
        .wake_q(wake_q), .in_standby(in_standby),
        .cpu_clk_en(cpu_clk_en), .div_sel(div_sel)
    );

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_CLKCTL: rd_data[DIV_W-1:0] = div_sel;
            A_LATCH:  rd_data[KEY_W-1:0] = key_in;
            A_WEN:    rd_data[IRQ_N:0]   = wake_en;
            A_SNAP:   rd_data[KEY_W-1:0] = snap;
        endcase
    end
endmodule

// File: tb/stby_wake_ctrl_tb_top.sv
module stby_wake_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [7:0]  key_in = '0;
    logic [5:0]  irq_in = '0;
    logic        cpu_clk_en;
    logic [2:0]  div_sel;
    int checks = 0, errors = 0;
    logic [15:0] rv;

    always #2.5 clk = ~clk;

    stby_wake_ctrl dut_i (.*);

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        rd_en = 1'b1; addr = a; #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // after wake condition applied at a negedge: low one more edge, then high
    task automatic expect_wake(string req);
        @(negedge clk);
        check(req, {15'b0, cpu_clk_en}, 16'd0);
        @(negedge clk);
        check(req, {15'b0, cpu_clk_en}, 16'd1);
        check("R8", {13'b0, div_sel}, 16'd3);
    endtask

    task automatic expect_hold(string req, int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            check(req, {15'b0, cpu_clk_en}, 16'd0);
        end
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1", {15'b0, cpu_clk_en}, 16'd1);
        check("R1", {13'b0, div_sel}, 16'd3);
        rd(2'd2, rv); check("R1", rv, 16'd0);
        rd(2'd3, rv); check("R1", rv, 16'd0);
        // R4 divider codes
        for (int d = 0; d < 7; d++) begin
            wr(2'd0, 16'(d));
            check("R4", {13'b0, div_sel}, 16'(d));
            rd(2'd0, rv); check("R4", rv, 16'(d));
        end
        // R2 latch read
        key_in = 8'hA5;
        rd(2'd1, rv); check("R2", rv, 16'h00A5);
        rd(2'd3, rv); check("R2", rv, 16'h00A5);
        // R9 in run: key differs, enabled; nothing changes
        wr(2'd2, 16'h0001);
        wr(2'd0, 16'd5);
        key_in = 8'h5A;
        repeat (4) @(negedge clk);
        check("R9", {15'b0, cpu_clk_en}, 16'd1);
        check("R9", {13'b0, div_sel}, 16'd5);
        key_in = 8'hA5;
        // R5 sweep over key bits
        for (int b = 0; b < 8; b++) begin
            wr(2'd0, 16'(b % 7));
            wr(2'd0, 16'd7);
            check("R3", {15'b0, cpu_clk_en}, 16'd0);
            check("R3", {13'b0, div_sel}, 16'(b % 7));
            expect_hold("R6", 3);
            key_in = 8'hA5 ^ (8'd1 << b);
            expect_wake("R5");
            key_in = 8'hA5;
        end
        // R6 key disabled: only IRQ1 enabled
        wr(2'd2, 16'h0002);
        wr(2'd0, 16'd7);
        key_in = 8'hFF;
        expect_hold("R6", 6);
        irq_in = 6'b000001;
        expect_wake("R7");
        irq_in = '0; key_in = 8'hA5;
        // R7 sweep over IRQ lines with masking
        for (int j = 0; j < 6; j++) begin
            wr(2'd2, 16'(1 << (j + 1)));
            wr(2'd0, 16'd7);
            irq_in = ~(6'd1 << j);
            expect_hold("R7", 4);
            irq_in = 6'h3F;
            expect_wake("R7");
            irq_in = '0;
        end
        // R10 key change after latch, before entry
        wr(2'd2, 16'h0001);
        key_in = 8'h3C;
        rd(2'd1, rv);
        key_in = 8'h3D;
        wr(2'd0, 16'd6);
        wr(2'd0, 16'd7);
        check("R10", {15'b0, cpu_clk_en}, 16'd0);
        @(negedge clk);
        check("R10", {15'b0, cpu_clk_en}, 16'd0);
        @(negedge clk);
        check("R10", {15'b0, cpu_clk_en}, 16'd1);
        check("R10", {13'b0, div_sel}, 16'd3);
        // R11 registers held across standby
        rd(2'd2, rv); check("R11", rv, 16'h0001);
        rd(2'd3, rv); check("R11", rv, 16'h003C);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule